// File: doc/BRIEF.md
# Serial Audio Frame Transmitter/Receiver

This block is the clock master of a serial audio link. From the system clock it produces a bit clock and a word-select line, and it shifts out two stereo output streams (four channels) that share that clock. At the same time it shifts in one stereo input stream. A frame lasts 64 bit slots of 16 system clocks each, so one frame is 1024 clocks. Slots 0..31 carry the left word and slots 32..63 carry the right word.

Each output word is 32 bits long. It starts with the sample, most significant bit first, at a chosen precision of 16, 18 or 20 bits. The last 12 slots of the word carry an auxiliary field. The slots between the sample and the auxiliary field carry zeros. Word select follows one of two timings. In left-justified timing it changes in the same slot as the MSB. In I2S timing it changes one slot earlier.

The parallel samples, the auxiliary fields and the configuration are latched once per frame. A one-cycle frame strobe marks that latch point. In the same cycle the strobe publishes the 16-bit left and right samples captured during the frame that just ended.

Top module: `sai_top`

## Requirements
- R1: While reset is high, `bclk_o`, `ws_o`, every `sdo_o` lane, `frame_o`, `rx_left_o` and `rx_right_o` are all zero.
- R2: `bclk_o` has a period of 2*HALF_DIV clocks (16 by default). It is low for the first HALF_DIV clocks of each slot and high for the remaining HALF_DIV clocks.
- R3: `frame_o` is high for exactly one clock every 64 slots (1024 clocks). Slot 0 of the next frame begins on the clock after the strobe.
- R4: In bit b (0..31) of a word, each lane sends sample bit 19-b while b is below the precision. Slot s belongs to the left word when s < 32 and to the right word otherwise, with b = s mod 32.
- R5: `cfg_prec_i` selects the precision: 0 gives 16 bits, 1 gives 18 bits, and 2 or 3 give 20 bits. Word bits from the precision up to bit 19 are sent as zero.
- R6: Word bits 20..31 carry the channel's 12-bit auxiliary field, MSB first, so that aux bit 31-b is sent in bit b.
- R7: With `cfg_mode_i`=1 (left-justified), `ws_o` is low in slots 0..31 and high in slots 32..63.
- R8: With `cfg_mode_i`=0 (I2S), `ws_o` is high in slots 31..62 and low otherwise. It therefore leads each word by one slot.
- R9: `ws_o` and `sdo_o` change only when `bclk_o` falls. They hold one value for the whole slot.
- R10: Samples, aux fields, mode and precision are sampled only in the `frame_o` cycle. Changing them at any other time does not affect the current frame.
- R11: `sdi_i` is sampled at each rising edge of `bclk_o`. Slots 0..15 form the left sample and slots 32..47 form the right sample, each MSB first. The results appear on `rx_left_o`/`rx_right_o` in the `frame_o` cycle and hold steady at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode_i | input | 1 | 0 = I2S word select, 1 = left-justified |
| cfg_prec_i | input | 2 | Output sample precision code |
| tx_smp_i | input | LANES*2*20 | Output samples, indexed [lane][0=left,1=right] |
| tx_aux_i | input | LANES*2*12 | Auxiliary fields, indexed [lane][channel] |
| sdi_i | input | 1 | Serial input data |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, high for right |
| sdo_o | output | LANES | Serial output data, one bit per lane |
| frame_o | output | 1 | One-cycle frame strobe |
| rx_left_o | output | RX_W | Captured left input sample |
| rx_right_o | output | RX_W | Captured right input sample |

## Verification
The hardest case to reach is an input change that lands mid-frame. The block must keep sending the latched words even when samples, aux fields, mode and precision all change while a frame is running. Every checked frame therefore replaces all of these inputs with inverted values and the opposite mode and precision at clock 300, and restores them just before the next latch point. Every slot after that change is then compared against the values latched at the start of the frame. The bench also drives ones into `sdi_i` on the unused input slots, so it can show that only slots 0..15 and 32..47 reach the captured samples.

// File: rtl/sai_pkg.sv
package sai_pkg;

    localparam int SMP_W  = 20;
    localparam int AUX_W  = 12;
    localparam int WORD_W = 32;
    localparam int SLOTS  = 2 * WORD_W;

    typedef enum logic {
        WSM_I2S  = 1'b0,
        WSM_LEFT = 1'b1
    } ws_mode_e;

    typedef enum logic [1:0] {
        PREC16  = 2'd0,
        PREC18  = 2'd1,
        PREC20  = 2'd2,
        PREC20X = 2'd3
    } prec_e;

    typedef struct packed {
        logic [SMP_W-1:0] smp;
        logic [AUX_W-1:0] aux;
    } chan_word_t;

    function automatic logic [4:0] prec_len(prec_e p);
        case (p)
            PREC16:  return 5'd16;
            PREC18:  return 5'd18;
            default: return 5'd20;
        endcase
    endfunction

    // Bit 'idx' (0 = first sent) of a 32-bit channel word
    function automatic logic word_bit(chan_word_t w, prec_e p, logic [4:0] idx);
        logic [4:0] si;
        logic [4:0] ai;
        si = 5'(SMP_W - 1) - idx;
        ai = 5'(WORD_W - 1) - idx;
        if (idx < prec_len(p))
            return w.smp[si];
        else if (idx < 5'(SMP_W))
            return 1'b0;
        else
            return w.aux[ai[3:0]];
    endfunction

endpackage

// File: rtl/sai_timebase.sv
module sai_timebase #(
    parameter int HALF_DIV = 8,
    parameter int SLOTS    = 64,
    localparam int PH_W    = $clog2(2 * HALF_DIV),
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot,
    output logic              mid,
    output logic              last,
    output logic              bclk_c
);
    logic [PH_W+SLOT_W-1:0] cnt_q;
    logic [PH_W-1:0]        phase;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign phase  = cnt_q[PH_W-1:0];
    assign slot   = cnt_q[PH_W+SLOT_W-1:PH_W];
    assign mid    = (phase == PH_W'(HALF_DIV));
    assign last   = &cnt_q;
    assign bclk_c = phase[PH_W-1];
endmodule

// File: rtl/sai_tx_lane.sv
module sai_tx_lane
    import sai_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_word_t left_w,
    input  chan_word_t right_w,
    input  prec_e      prec,
    input  logic [5:0] slot,
    output logic       sdo
);
    chan_word_t cur_w;
    logic       bit_c;

    always_comb begin
        cur_w = slot[5] ? right_w : left_w;
        bit_c = word_bit(cur_w, prec, slot[4:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) sdo <= 1'b0;
        else     sdo <= bit_c;
    end
endmodule

// File: rtl/sai_rx.sv
module sai_rx #(
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sdi,
    input  logic            sample_en,
    input  logic [5:0]      slot,
    input  logic            publish,
    output logic [RX_W-1:0] rx_left,
    output logic [RX_W-1:0] rx_right
);
    logic [RX_W-1:0] sh_q, hold_l, hold_r, sh_next;
    logic            in_field, field_end;

    always_comb begin
        sh_next   = {sh_q[RX_W-2:0], sdi};
        in_field  = ({27'd0, slot[4:0]} < 32'(RX_W));
        field_end = ({27'd0, slot[4:0]} == 32'(RX_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            hold_l   <= '0;
            hold_r   <= '0;
            rx_left  <= '0;
            rx_right <= '0;
        end else begin
            if (sample_en && in_field) begin
                sh_q <= sh_next;
                if (field_end) begin
                    if (slot[5]) hold_r <= sh_next;
                    else         hold_l <= sh_next;
                end
            end
            if (publish) begin
                rx_left  <= hold_l;
                rx_right <= hold_r;
            end
        end
    end
endmodule

// File: rtl/sai_top.sv
module sai_top
    import sai_pkg::*;
#(
    parameter int HALF_DIV = 8,
    parameter int LANES    = 2,
    parameter int RX_W     = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_mode_i,
    input  logic [1:0]                         cfg_prec_i,
    input  logic [LANES-1:0][1:0][SMP_W-1:0]   tx_smp_i,
    input  logic [LANES-1:0][1:0][AUX_W-1:0]   tx_aux_i,
    input  logic                               sdi_i,
    output logic                               bclk_o,
    output logic                               ws_o,
    output logic [LANES-1:0]                   sdo_o,
    output logic                               frame_o,
    output logic [RX_W-1:0]                    rx_left_o,
    output logic [RX_W-1:0]                    rx_right_o
);
    logic [5:0] slot, slot_p1;
    logic       mid, last, bclk_c, ws_c;

    ws_mode_e   mode_q;
    prec_e      prec_q;
    chan_word_t word_q [LANES][2];

    sai_timebase #(.HALF_DIV(HALF_DIV), .SLOTS(SLOTS)) u_tb (
        .clk(clk), .rst(rst), .slot(slot), .mid(mid), .last(last), .bclk_c(bclk_c)
    );

    // Per-frame shadow of configuration and samples
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= WSM_I2S;
            prec_q <= PREC16;
            for (int l = 0; l < LANES; l++)
                for (int c = 0; c < 2; c++)
                    word_q[l][c] <= '0;
        end else if (last) begin
            mode_q <= ws_mode_e'(cfg_mode_i);
            prec_q <= prec_e'(cfg_prec_i);
            for (int l = 0; l < LANES; l++)
                for (int c = 0; c < 2; c++)
                    word_q[l][c] <= '{smp: tx_smp_i[l][c], aux: tx_aux_i[l][c]};
        end
    end

    always_comb begin
        slot_p1 = slot + 6'd1;
        ws_c    = (mode_q == WSM_LEFT) ? slot[5] : slot_p1[5];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_o  <= 1'b0;
            ws_o    <= 1'b0;
            frame_o <= 1'b0;
        end else begin
            bclk_o  <= bclk_c;
            ws_o    <= ws_c;
            frame_o <= last;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sai_tx_lane u_lane (
            .clk(clk), .rst(rst),
            .left_w(word_q[g][0]), .right_w(word_q[g][1]),
            .prec(prec_q), .slot(slot), .sdo(sdo_o[g])
        );
    end

    sai_rx #(.RX_W(RX_W)) u_rx (
        .clk(clk), .rst(rst), .sdi(sdi_i), .sample_en(mid), .slot(slot),
        .publish(last), .rx_left(rx_left_o), .rx_right(rx_right_o)
    );
endmodule

// File: rtl/sai_chk.sv
module sai_chk #(
    parameter int HALF_DIV = 8,
    parameter int LANES    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             bclk_o,
    input logic             ws_o,
    input logic [LANES-1:0] sdo_o,
    input logic             frame_o
);
    logic        bclk_d, seen;
    logic [15:0] level_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d    <= 1'b0;
            seen      <= 1'b0;
            level_len <= '0;
        end else begin
            bclk_d <= bclk_o;
            if (bclk_o != bclk_d) begin
                seen      <= 1'b1;
                level_len <= '0;
            end else begin
                level_len <= level_len + 16'd1;
            end
        end
    end

    // R2
    bclk_half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && bclk_o != bclk_d) |-> (level_len == 16'(HALF_DIV - 1)));

    // R3
    frame_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_o |=> !frame_o);

    // R3
    frame_slot0_chk: assert property (@(posedge clk) disable iff (rst)
        frame_o |=> (!bclk_o && !ws_o));

    // R9
    ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (ws_o != $past(ws_o)) |-> $fell(bclk_o));

    // R9
    stable_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_o) |-> ($stable(ws_o) && $stable(sdo_o)));

    for (genvar g = 0; g < LANES; g++) begin : g_l
        // R9
        sdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
            (sdo_o[g] != $past(sdo_o[g])) |-> $fell(bclk_o));
    end
endmodule

bind sai_top sai_chk #(.HALF_DIV(HALF_DIV), .LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .bclk_o(bclk_o), .ws_o(ws_o),
    .sdo_o(sdo_o), .frame_o(frame_o)
);

// File: tb/tb_sai_top.sv
module tb_sai_top;
    localparam int LANES = 2;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic                         cfg_mode_i = 1'b0;
    logic [1:0]                   cfg_prec_i = 2'd0;
    logic [LANES-1:0][1:0][19:0]  tx_smp_i = '0;
    logic [LANES-1:0][1:0][11:0]  tx_aux_i = '0;
    logic                         sdi_i = 1'b0;
    logic                         bclk_o, ws_o, frame_o;
    logic [LANES-1:0]             sdo_o;
    logic [15:0]                  rx_left_o, rx_right_o;

    sai_top #(.HALF_DIV(8), .LANES(LANES), .RX_W(16)) dut (
        .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode_i), .cfg_prec_i(cfg_prec_i),
        .tx_smp_i(tx_smp_i), .tx_aux_i(tx_aux_i), .sdi_i(sdi_i),
        .bclk_o(bclk_o), .ws_o(ws_o), .sdo_o(sdo_o), .frame_o(frame_o),
        .rx_left_o(rx_left_o), .rx_right_o(rx_right_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic                         cur_mode;
    logic [1:0]                   cur_prec;
    logic [LANES-1:0][1:0][19:0]  cur_smp;
    logic [LANES-1:0][1:0][11:0]  cur_aux;
    logic [15:0]                  cur_rxl, cur_rxr;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_bit(logic [19:0] s, logic [11:0] a, logic [1:0] p, int b);
        int n;
        n = (p == 2'd0) ? 16 : (p == 2'd1) ? 18 : 20;
        if (b < n)       return s[19-b];
        else if (b < 20) return 1'b0;
        else             return a[31-b];
    endfunction

    task automatic apply_cur();
        cfg_mode_i = cur_mode;
        cfg_prec_i = cur_prec;
        tx_smp_i   = cur_smp;
        tx_aux_i   = cur_aux;
    endtask

    task automatic scramble();
        cfg_mode_i = ~cur_mode;
        cfg_prec_i = ~cur_prec;
        tx_smp_i   = ~cur_smp;
        tx_aux_i   = ~cur_aux;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (frame_o !== 1'b1);
    endtask

    // Called at the negedge in which frame_o is high; checks the whole frame.
    task automatic run_frame(string name);
        int e_bclk = 0, e_frame = 0, e_ws = 0, e_smp = 0, e_pad = 0;
        int e_aux = 0, e_late = 0, e_stab = 0;
        int n = (cur_prec == 2'd0) ? 16 : (cur_prec == 2'd1) ? 18 : 20;
        logic [LANES-1:0] midv = '0;
        logic [15:0] held_l = '0, held_r = '0;
        for (int t = 1; t <= 1024; t++) begin
            int c, ph, s, b, sd, bd;
            logic ews;
            @(negedge clk);
            c = t - 1; ph = c % 16; s = c / 16; b = s % 32;
            if (bclk_o !== (ph >= 8)) e_bclk++;
            if (frame_o !== (t == 1024)) e_frame++;
            if (ph == 8) begin
                ews = cur_mode ? (s >= 32) : (s >= 31 && s <= 62);
                if (ws_o !== ews) begin e_ws++; if (t > 300) e_late++; end
                for (int l = 0; l < LANES; l++) begin
                    logic eb;
                    eb = exp_bit(cur_smp[l][s/32], cur_aux[l][s/32], cur_prec, b);
                    midv[l] = sdo_o[l];
                    if (sdo_o[l] !== eb) begin
                        if (b < n) e_smp++; else if (b < 20) e_pad++; else e_aux++;
                        if (t > 300) e_late++;
                    end
                end
            end
            if (ph == 15 && sdo_o !== midv) e_stab++;
            if (ph == 15 && ws_o !== (cur_mode ? (s >= 32) : (s >= 31 && s <= 62))) e_stab++;
            // drive sdi for the slot whose rising edge follows
            sd = (t / 16) % 64; bd = sd % 32;
            if (bd < 16) sdi_i = (sd < 32) ? cur_rxl[15-bd] : cur_rxr[15-bd];
            else         sdi_i = 1'b1;
            if (t == 300)  scramble();
            if (t == 1020) apply_cur();
            if (t == 600) begin held_l = rx_left_o; held_r = rx_right_o; end
            if (t == 1023) begin
                chk(rx_left_o === held_l && rx_right_o === held_r,
                    {name, " R11 rx held mid-frame"}, int'(rx_left_o), int'(held_l));
            end
        end
        chk(e_bclk == 0,  {name, " R2 bclk shape errors"}, e_bclk, 0);
        chk(e_frame == 0, {name, " R3 frame strobe errors"}, e_frame, 0);
        chk(e_ws == 0, {name, cur_mode ? " R7 ws errors" : " R8 ws errors"}, e_ws, 0);
        chk(e_smp == 0,   {name, " R4 sample bit errors"}, e_smp, 0);
        chk(e_pad == 0,   {name, " R5 pad bit errors"}, e_pad, 0);
        chk(e_aux == 0,   {name, " R6 aux bit errors"}, e_aux, 0);
        chk(e_stab == 0,  {name, " R9 mid-slot change errors"}, e_stab, 0);
        chk(e_late == 0,  {name, " R10 errors after input change"}, e_late, 0);
        chk(rx_left_o === cur_rxl, {name, " R11 rx left"}, int'(rx_left_o), int'(cur_rxl));
        chk(rx_right_o === cur_rxr, {name, " R11 rx right"}, int'(rx_right_o), int'(cur_rxr));
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(bclk_o === 1'b0 && ws_o === 1'b0 && frame_o === 1'b0, "R1 reset clocks", int'({bclk_o, ws_o, frame_o}), 0);
        chk(sdo_o === '0, "R1 reset sdo", int'(sdo_o), 0);
        chk(rx_left_o === '0 && rx_right_o === '0, "R1 reset rx", int'(rx_left_o), 0);
    endtask

    task automatic test_left20();
        cur_mode = 1'b1; cur_prec = 2'd2;
        cur_smp = {20'hF0F0F, 20'h12345, 20'hABCDE, 20'h80001};
        cur_aux = {12'hA5A, 12'h3C3, 12'h801, 12'hFFE};
        cur_rxl = 16'hA5C3; cur_rxr = 16'h3C5A;
        apply_cur(); wait_frame(); run_frame("left20");
    endtask

    task automatic test_i2s18();
        cur_mode = 1'b0; cur_prec = 2'd1;
        cur_smp = {20'hFFFFF, 20'h00001, 20'h55555, 20'hAAAAA};
        cur_aux = {12'h001, 12'h800, 12'hF0F, 12'h0F0};
        cur_rxl = 16'h8001; cur_rxr = 16'hFFFF;
        apply_cur(); wait_frame(); run_frame("i2s18");
    endtask

    task automatic test_left16();
        cur_mode = 1'b1; cur_prec = 2'd0;
        cur_smp = {20'hFFFFF, 20'hFFFFF, 20'h7FFFF, 20'hC3C3C};
        cur_aux = {12'h000, 12'hFFF, 12'h5A5, 12'h123};
        cur_rxl = 16'h0000; cur_rxr = 16'h1234;
        apply_cur(); wait_frame(); run_frame("left16");
    endtask

    task automatic test_i2s_code3();
        cur_mode = 1'b0; cur_prec = 2'd3;
        cur_smp = {20'h0000F, 20'hE0000, 20'h96969, 20'h00800};
        cur_aux = {12'hC00, 12'h003, 12'h999, 12'h666};
        cur_rxl = 16'h7FFE; cur_rxr = 16'h0001;
        apply_cur(); wait_frame(); run_frame("i2s20code3");
    endtask

    initial begin
        test_reset();
        @(negedge clk); rst = 1'b0;
        test_left20();
        test_i2s18();
        test_left16();
        test_i2s_code3();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule